// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block fetches transmit work from a ring of 8-byte buffer descriptors kept in system memory. It reaches memory through a word-wide request/acknowledge port. It gathers the bytes of each frame from one or more buffers and presents them on a byte-wide valid/ready stream. The final byte of each frame is marked with a last flag. After each buffer is drained, the block writes the descriptor back so that software owns it again. It also pulses event lines that an interrupt block elsewhere can collect.

Software first loads the ring base address and fills descriptors with the ready bit set. While the controller enable input is high, it then pulses the demand input. The walker keeps following descriptors until it reads one whose ready bit is clear. The current pointer stays on that descriptor, so the next demand resumes there.

On the output stream, a byte is transferred in any cycle where `tx_valid` and `tx_ready` are both high. While `tx_ready` is low the byte is held, and the walker issues no further memory reads for the buffer. The sink may hold `tx_ready` low for any number of cycles.

Top module: `txbd_ring_engine`

## Requirements
- R1: After reset, `mem_req`, `tx_valid`, `busy` and all three event outputs are low, and both the ring base and the current pointer are zero.
- R2: A demand pulse has an effect only while `ctrl_enable` is high. With `ctrl_enable` low it starts no walk, issues no memory access and sends no bytes.
- R3: Each descriptor occupies two words. The word at the pointer holds the flags in bits 31:16 and the byte length in bits 15:0. The word at pointer+4 holds the buffer byte address. In the flags, bit 15 is ready, bit 13 is wrap and bit 11 is last. A descriptor read with ready clear ends the walk and leaves the pointer on it.
- R4: A buffer's bytes are streamed in address order from its byte address, whatever the alignment. Within each memory word, the byte in bits 31:24 comes first. While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold steady.
- R5: `tx_last` is high on exactly the final byte sent from a buffer whose last bit is set. A buffer that contributes zero bytes sends nothing.
- R6: After a buffer is consumed, the first descriptor word is written back with bit 15 cleared and every other flag and the length unchanged. `evt_txbuf` then pulses for one cycle. `evt_txframe` pulses in the same cycle when the buffer had the last bit set.
- R7: The bytes sent in one frame never exceed `MAX_FRAME` (2032 by default). A buffer whose length would pass that cap is cut to fit, and `evt_babble` pulses together with its `evt_txbuf`. The frame count restarts at zero after a last buffer.
- R8: After a write-back, the pointer moves to the ring base if the wrap bit was set, and to the current pointer plus 8 otherwise.
- R9: A `base_wr` pulse loads the ring base with `base_wdata` with bits 1:0 forced to zero, and loads the current pointer with the same value.
- R10: A valid demand that arrives while a walk is running is remembered. When the walk next meets a descriptor with ready clear, it reads that same descriptor once more before going idle.
- R11: `mem_req` is held with `mem_addr`, `mem_we` and `mem_wdata` stable until `mem_ack` is seen, and `mem_addr` is always word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_enable | input | 1 | Controller enable; gates demand pulses |
| demand_wr | input | 1 | One-cycle transmit demand pulse |
| base_wr | input | 1 | One-cycle ring base write strobe |
| base_wdata | input | ADDR_W | Ring base address value |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | ADDR_W | Word-aligned memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Access done; read data valid this cycle |
| mem_rdata | input | 32 | Memory read data |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | Stream sink ready |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of a frame |
| evt_txbuf | output | 1 | Buffer consumed pulse |
| evt_txframe | output | 1 | Frame completed pulse |
| evt_babble | output | 1 | Frame cut at size cap pulse |
| busy | output | 1 | Walk in progress |

## Verification
`busy` rises on the first edge after an accepted demand, and the descriptor read request is already on the port in that cycle. Every event pulse appears one cycle after the write-back acknowledge. The timing of stream bytes depends on memory acknowledge latency and on `tx_ready`, so the bench captures each byte on its handshake edge. After `busy` falls, it compares the captured bytes, the position of the last marker, the event counts and the written-back descriptors against values worked out from the descriptors it placed in memory. Only the reset state and the rise of `busy` are checked at a fixed cycle, and both are sampled on the falling edge after the register that drives them.

// File: rtl/txbd_pkg.sv
package txbd_pkg;
  // descriptor flag bit positions (flags live in word bits 31:16)
  localparam int FLAG_READY = 15;
  localparam int FLAG_WRAP  = 13;
  localparam int FLAG_LAST  = 11;
  localparam int BD_BYTES   = 8;

  typedef enum logic [2:0] {
    S_IDLE,
    S_HEAD,
    S_PTR,
    S_FETCH,
    S_SEND,
    S_BACK
  } walk_state_t;
endpackage

// File: rtl/txbd_len_cap.sv
module txbd_len_cap #(
  parameter int MAX_FRAME = 2032,
  parameter int CNT_W     = $clog2(MAX_FRAME + 1)
) (
  input  logic [CNT_W-1:0] frame_cnt,
  input  logic [15:0]      req_len,
  output logic [15:0]      grant_len,
  output logic             cut
);
  logic [16:0] room;

  always_comb begin
    room      = 17'(MAX_FRAME) - 17'(frame_cnt);
    cut       = {1'b0, req_len} > room;
    grant_len = cut ? room[15:0] : req_len;
  end
endmodule

// File: rtl/txbd_byte_lane.sv
module txbd_byte_lane #(
  parameter int WORD_BYTES = 4,
  localparam int LANE_W    = $clog2(WORD_BYTES)
) (
  input  logic [8*WORD_BYTES-1:0] word,
  input  logic [LANE_W-1:0]       lane,
  output logic [7:0]              byte_out
);
  logic [7:0] lanes [WORD_BYTES];

  // lane 0 is the most significant byte of the word
  for (genvar i = 0; i < WORD_BYTES; i++) begin : g_lane
    assign lanes[i] = word[8*(WORD_BYTES-1-i) +: 8];
  end

  assign byte_out = lanes[lane];
endmodule

// File: rtl/txbd_ring_engine.sv
module txbd_ring_engine
  import txbd_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MAX_FRAME = 2032,
  localparam int CNT_W    = $clog2(MAX_FRAME + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_enable,
  input  logic              demand_wr,
  input  logic              base_wr,
  input  logic [ADDR_W-1:0] base_wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  output logic              evt_txbuf,
  output logic              evt_txframe,
  output logic              evt_babble,
  output logic              busy
);
  walk_state_t       state;
  logic [ADDR_W-1:0] base_ptr, cur_ptr, baddr;
  logic [15:0]       flags_q, len_q, rem;
  logic [31:0]       wbuf;
  logic [CNT_W-1:0]  fcnt;
  logic              cut_q, pending;
  logic [15:0]       grant, wb_flags;
  logic              cut;
  logic              demand_ok;

  assign demand_ok = demand_wr && ctrl_enable;

  txbd_len_cap #(.MAX_FRAME(MAX_FRAME), .CNT_W(CNT_W)) u_cap (
    .frame_cnt (fcnt),
    .req_len   (len_q),
    .grant_len (grant),
    .cut       (cut)
  );

  txbd_byte_lane #(.WORD_BYTES(4)) u_lane (
    .word     (wbuf),
    .lane     (baddr[1:0]),
    .byte_out (tx_data)
  );

  always_comb begin
    wb_flags             = flags_q;
    wb_flags[FLAG_READY] = 1'b0;
    mem_req   = (state == S_HEAD) || (state == S_PTR) ||
                (state == S_FETCH) || (state == S_BACK);
    mem_we    = (state == S_BACK);
    mem_wdata = {wb_flags, len_q};
    case (state)
      S_PTR:   mem_addr = cur_ptr + ADDR_W'(4);
      S_FETCH: mem_addr = {baddr[ADDR_W-1:2], 2'b00};
      default: mem_addr = cur_ptr;
    endcase
  end

  assign tx_valid = (state == S_SEND);
  assign tx_last  = (state == S_SEND) && flags_q[FLAG_LAST] && (rem == 16'd1);
  assign busy     = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      base_ptr    <= '0;
      cur_ptr     <= '0;
      baddr       <= '0;
      flags_q     <= '0;
      len_q       <= '0;
      rem         <= '0;
      wbuf        <= '0;
      fcnt        <= '0;
      cut_q       <= 1'b0;
      pending     <= 1'b0;
      evt_txbuf   <= 1'b0;
      evt_txframe <= 1'b0;
      evt_babble  <= 1'b0;
    end else begin
      evt_txbuf   <= 1'b0;
      evt_txframe <= 1'b0;
      evt_babble  <= 1'b0;
      if (state != S_IDLE && demand_ok) pending <= 1'b1;
      case (state)
        S_IDLE: if (demand_ok) state <= S_HEAD;
        S_HEAD: if (mem_ack) begin
          flags_q <= mem_rdata[31:16];
          len_q   <= mem_rdata[15:0];
          if (!mem_rdata[16+FLAG_READY]) begin
            if (pending || demand_ok) pending <= 1'b0;
            else                      state   <= S_IDLE;
          end else begin
            state <= S_PTR;
          end
        end
        S_PTR: if (mem_ack) begin
          baddr <= mem_rdata[ADDR_W-1:0];
          rem   <= grant;
          fcnt  <= fcnt + CNT_W'(grant);
          cut_q <= cut;
          state <= (grant == 16'd0) ? S_BACK : S_FETCH;
        end
        S_FETCH: if (mem_ack) begin
          wbuf  <= mem_rdata;
          state <= S_SEND;
        end
        S_SEND: if (tx_ready) begin
          baddr <= baddr + ADDR_W'(1);
          rem   <= rem - 16'd1;
          if (rem == 16'd1)            state <= S_BACK;
          else if (baddr[1:0] == 2'b11) state <= S_FETCH;
        end
        S_BACK: if (mem_ack) begin
          evt_txbuf  <= 1'b1;
          evt_babble <= cut_q;
          if (flags_q[FLAG_LAST]) begin
            evt_txframe <= 1'b1;
            fcnt        <= '0;
          end
          cur_ptr <= flags_q[FLAG_WRAP] ? base_ptr : cur_ptr + ADDR_W'(BD_BYTES);
          state   <= S_HEAD;
        end
        default: state <= S_IDLE;
      endcase
      if (base_wr) begin
        base_ptr <= {base_wdata[ADDR_W-1:2], 2'b00};
        cur_ptr  <= {base_wdata[ADDR_W-1:2], 2'b00};
      end
    end
  end
endmodule

// File: rtl/txbd_ring_engine_chk.sv
module txbd_ring_engine_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctrl_enable,
  input logic              demand_wr,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_wdata,
  input logic              mem_ack,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [7:0]        tx_data,
  input logic              tx_last,
  input logic              evt_txbuf,
  input logic              evt_txframe,
  input logic              evt_babble,
  input logic              busy
);
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  assert_addr_aligned_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  assert_stream_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  assert_frame_evt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_txframe |-> evt_txbuf);

  assert_babble_evt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_babble |-> evt_txbuf);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !tx_valid));

  assert_disabled_demand_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && demand_wr && !ctrl_enable) |=> !busy);

  assert_start_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(demand_wr && ctrl_enable));
endmodule

bind txbd_ring_engine txbd_ring_engine_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/txbd_ring_engine_tb.sv
`timescale 1ns/1ps
module txbd_ring_engine_tb;
  localparam logic [15:0] F_R = 16'h8000, F_W = 16'h2000, F_L = 16'h0800;
  // row: {len0, buf0, len1, buf1}; len1 == 0 means a single buffer frame
  localparam logic [63:0] TBL [4] = '{
    {16'd5, 16'h1001, 16'd0, 16'h0000},
    {16'd3, 16'h2002, 16'd6, 16'h3003},
    {16'd8, 16'h1000, 16'd1, 16'h4007},
    {16'd0, 16'h1000, 16'd4, 16'h5000}
  };

  logic clk = 0, rst_n = 0;
  logic ctrl_enable = 0, demand_wr = 0, base_wr = 0;
  logic [31:0] base_wdata = 0;
  logic mem_req, mem_we, mem_ack = 0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = 0;
  logic tx_valid, tx_ready = 1, tx_last;
  logic [7:0] tx_data;
  logic evt_txbuf, evt_txframe, evt_babble, busy;

  int checks = 0, errors = 0;
  logic stall = 0;
  logic host_we = 0;
  logic [31:0] host_a = 0, host_d = 0, watch_addr = 32'hFFFF_FFFF;
  logic [31:0] dmem [64];
  logic [7:0]  rxb [4096];
  int nbytes = 0, nlast = 0, last_idx = 0, n_buf = 0, n_frame = 0, n_bab = 0, watch_reads = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  txbd_ring_engine u_dut (.*);

  function automatic logic [7:0] bval(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  function automatic logic [31:0] rd_word(input logic [31:0] a);
    if (a < 32'd256) return dmem[a[7:2]];
    return {bval(a), bval(a + 1), bval(a + 2), bval(a + 3)};
  endfunction

  // memory model: one-cycle acknowledge, host pokes applied here
  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (host_we) dmem[host_a[7:2]] <= host_d;
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        if (mem_addr < 32'd256) dmem[mem_addr[7:2]] <= mem_wdata;
      end else begin
        mem_rdata <= rd_word(mem_addr);
        if (mem_addr == watch_addr) watch_reads <= watch_reads + 1;
      end
    end
  end

  // stream and event monitor
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (tx_valid && tx_ready) begin
      rxb[nbytes % 4096] <= tx_data;
      if (tx_last) begin
        nlast    <= nlast + 1;
        last_idx <= nbytes;
      end
      nbytes <= nbytes + 1;
    end
    if (evt_txbuf)   n_buf   <= n_buf + 1;
    if (evt_txframe) n_frame <= n_frame + 1;
    if (evt_babble)  n_bab   <= n_bab + 1;
  end

  always @(negedge clk) tx_ready <= !stall || (cyc[0] ^ cyc[2]);

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); host_we = 1; host_a = a; host_d = d;
    @(negedge clk); host_we = 0;
  endtask

  task automatic set_base(input logic [31:0] v);
    @(negedge clk); base_wr = 1; base_wdata = v;
    @(negedge clk); base_wr = 0;
  endtask

  task automatic run_walk();
    @(negedge clk); demand_wr = 1;
    @(negedge clk); demand_wr = 0;
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // compare a captured frame against two buffers (l1 may be 0)
  task automatic chk_frame(input string tag, input int s0, input int last0,
                           input logic [31:0] a0, input int l0, input logic [31:0] a1, input int l1,
                           input int cap);
    int tot, bad;
    logic [7:0] e;
    tot = (l0 + l1 > cap) ? cap : l0 + l1;
    bad = 0;
    for (int i = 0; i < tot; i++) begin
      e = (i < l0) ? bval(a0 + i) : bval(a1 + i - l0);
      if (rxb[(s0 + i) % 4096] !== e) bad++;
    end
    check(nbytes - s0 == tot, {tag, " R4 byte count"}, nbytes - s0, tot);
    check(bad == 0, {tag, " R4 byte content"}, bad, 0);
    check(nlast - last0 == 1 && last_idx == s0 + tot - 1, {tag, " R5 last marker"}, last_idx, s0 + tot - 1);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int s0, l0c, b0c, fc, bb, rd;
    for (int i = 0; i < 64; i++) dmem[i] = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!mem_req && !tx_valid && !busy, "R1 reset outputs", {mem_req, tx_valid, busy}, 0);
    check(!evt_txbuf && !evt_txframe && !evt_babble, "R1 reset events", {evt_txbuf, evt_txframe, evt_babble}, 0);
    rst_n = 1;
    @(negedge clk);

    // R9 base write masks low bits
    set_base(32'h0000_0041);

    // R2 demand ignored while disabled
    poke(32'h40, {F_R | F_L | F_W, 16'd5});
    poke(32'h44, 32'h1001);
    s0 = nbytes;
    @(negedge clk); demand_wr = 1;
    @(negedge clk); demand_wr = 0;
    check(!busy, "R2 no start when disabled", busy, 0);
    repeat (20) @(negedge clk);
    check(nbytes == s0 && dmem[16][31] == 1'b1, "R2 nothing sent or written", nbytes - s0, 0);
    ctrl_enable = 1;

    // R2 busy rises one cycle after an accepted demand
    @(negedge clk); demand_wr = 1;
    @(negedge clk); demand_wr = 0;
    check(busy && mem_req && mem_addr == 32'h40, "R2 R9 walk starts at masked base", mem_addr, 32'h40);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    chk_frame("pre", s0, 0, 32'h1001, 5, 32'h0, 0, 2032);

    // table of frames, all on the same ring base
    foreach (TBL[i]) begin
      logic [15:0] L0, B0, L1, B1;
      int lstart, nb;
      {L0, B0, L1, B1} = TBL[i];
      stall = (i == 2);
      if (L1 == 0) begin
        poke(32'h40, {F_R | F_L | F_W, L0});
        poke(32'h44, {16'h0, B0});
      end else begin
        poke(32'h40, {F_R, L0});
        poke(32'h44, {16'h0, B0});
        poke(32'h48, {F_R | F_L | F_W, L1});
        poke(32'h4C, {16'h0, B1});
      end
      s0 = nbytes; lstart = nlast; b0c = n_buf; fc = n_frame; bb = n_bab;
      run_walk();
      nb = (L1 == 0) ? 1 : 2;
      chk_frame($sformatf("row%0d", i), s0, lstart, {16'h0, B0}, int'(L0), {16'h0, B1}, int'(L1), 2032);
      check(n_buf - b0c == nb && n_frame - fc == 1, "R6 event counts", n_buf - b0c, nb);
      check(dmem[16] == {(L1 == 0) ? (F_L | F_W) : 16'h0, L0}, "R6 write-back word", dmem[16], {16'h0, L0});
      check(n_bab == bb, "R7 no babble under cap", n_bab - bb, 0);
    end
    stall = 0;

    // R3 stop on ready clear, pointer stays
    watch_addr = 32'h40;
    rd = watch_reads; s0 = nbytes;
    run_walk();
    check(watch_reads - rd == 1 && nbytes == s0, "R3 single read at stop descriptor", watch_reads - rd, 1);

    // R8 advance by 8 without wrap
    poke(32'h40, {F_R | F_L, 16'd2});
    poke(32'h44, 32'h6000);
    poke(32'h48, 32'h0);
    s0 = nbytes; l0c = nlast;
    run_walk();
    chk_frame("nowrap", s0, l0c, 32'h6000, 2, 32'h0, 0, 2032);
    poke(32'h48, {F_R | F_L | F_W, 16'd3});
    poke(32'h4C, 32'h7000);
    s0 = nbytes; l0c = nlast;
    run_walk();
    chk_frame("R8 next at plus 8", s0, l0c, 32'h7000, 3, 32'h0, 0, 2032);

    // R10 demand during walk causes a second read of the stop descriptor
    poke(32'h40, {F_R | F_L, 16'd40});
    poke(32'h44, 32'h1000);
    poke(32'h48, 32'h0);
    watch_addr = 32'h48;
    stall = 1;
    rd = watch_reads;
    @(negedge clk); demand_wr = 1;
    @(negedge clk); demand_wr = 0;
    repeat (3) @(negedge clk);
    demand_wr = 1;
    @(negedge clk); demand_wr = 0;
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    stall = 0;
    check(watch_reads - rd == 2, "R10 extra pass after pending demand", watch_reads - rd, 2);

    // R9 base reload with low bits set
    set_base(32'h0000_0083);
    poke(32'h80, {F_R | F_L | F_W, 16'd4});
    poke(32'h84, 32'h1234);
    s0 = nbytes; l0c = nlast;
    run_walk();
    chk_frame("R9 reload", s0, l0c, 32'h1234, 4, 32'h0, 0, 2032);

    // R7 oversize frame cut at cap
    poke(32'h80, {F_R | F_L | F_W, 16'd2040});
    poke(32'h84, 32'h1000);
    s0 = nbytes; l0c = nlast; bb = n_bab;
    run_walk();
    chk_frame("R7 cap", s0, l0c, 32'h1000, 2040, 32'h0, 0, 2032);
    check(n_bab - bb == 1, "R7 babble event", n_bab - bb, 1);
    check(dmem[32] == {F_L | F_W, 16'd2040}, "R7 length kept in write-back", dmem[32], {F_L | F_W, 16'd2040});

    // R7 count restarts after last
    poke(32'h80, {F_R | F_L | F_W, 16'd10});
    s0 = nbytes; l0c = nlast; bb = n_bab;
    run_walk();
    chk_frame("R7 restart", s0, l0c, 32'h1000, 10, 32'h0, 0, 2032);
    check(n_bab == bb, "R7 no babble after restart", n_bab - bb, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule